// File: doc/BRIEF.md
# Triggered Retriggerable PWM Timer

A counter-based pulse generator that, once enabled, parks its counter at the all-ones value and waits for a start event. The start event is either a one-cycle software strobe or a chosen transition on an external pin. On each start event the counter restarts from zero. From then on it produces a periodic PWM waveform. The period and high-time come from two compare registers that are double-buffered. A second output flips its level on every start event. Two single-cycle pulses mark the end of each period and the point where the high-time runs out.

Counting advances only on cycles where the count-enable strobe is high, so an outside prescaler can set the count rate. A start event that arrives while the counter runs cuts the current period short and begins a new one. Compare values written during operation wait in their registers. They reach the comparators only at a period boundary, so a running waveform never sees a half-updated pair. Dropping the enable parks the timer again and copies the registers straight into the buffers.

Top module: `trig_pwm_timer`

## Requirements
- R1: After reset, and after enabling without any start event, the counter holds at all-ones. pwm_out, tgl_out, per_hit and dty_hit stay low however many cycles pass.
- R2: sw_start high at a rising clock edge while run_en is high is a start event at that same edge. Held for one cycle, it acts once.
- R3: At a start event the counter becomes 0 and pwm_out goes high, whatever its previous level. tgl_out inverts. Neither match pulse is raised for that edge.
- R4: A start event while the counter runs restarts the period from count 0.
- R5: On each edge with cnt_en high, the running counter advances by one. When it equals the period buffer P, it clears to 0 instead, so one cycle spans P+1 count steps. The clearing edge raises per_hit for exactly one cycle.
- R6: With duty buffer D, pwm_out is high for counts 0..D-1 of each period. When the count reaches D, pwm_out goes low and dty_hit pulses for one cycle. If D is 0, the output is low for whole periods after the first clear, and dty_hit pulses at each clear. If D exceeds P, the output stays high and dty_hit never pulses.
- R7: Register writes (per_wr/per_data, dty_wr/dty_data) reach the period and duty buffers only at the clearing edge at the end of a period. The period in progress keeps its old values.
- R8: edge_sel picks the pin event: 00 none, 01 rising, 10 falling, 11 both. ext_start passes two synchronizer flops and an edge register, so a level change made between edges acts at the third rising edge after it.
- R9: While cnt_en is low, the running counter, pwm_out and tgl_out hold, and no match pulse is raised.
- R10: With run_en low, the counter is forced to all-ones and all outputs are low. Start events are ignored, and the buffers load directly from the registers each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Timer enable level |
| cnt_en | input | 1 | Count-enable strobe |
| sw_start | input | 1 | Software start strobe, one cycle per event |
| edge_sel | input | 2 | Pin event select: 00 none, 01 rise, 10 fall, 11 both |
| ext_start | input | 1 | Asynchronous external start pin |
| per_wr | input | 1 | Write strobe for the period register |
| per_data | input | WIDTH | Period value P |
| dty_wr | input | 1 | Write strobe for the duty register |
| dty_data | input | WIDTH | Duty value D |
| pwm_out | output | 1 | PWM waveform |
| tgl_out | output | 1 | Level that flips on every start event |
| per_hit | output | 1 | One-cycle pulse at each period clear |
| dty_hit | output | 1 | One-cycle pulse when the count reaches D |

## Verification
The assertions take run_en to be low while reset is held. They also take ext_start to be a slow level, so the synchronizer is never asked to resolve a glitch. The bench holds run_en low through reset. It moves every input on the falling clock edge and keeps each ext_start level for at least three cycles before changing it again, so every pin event is a clean, isolated transition. Software strobes and register writes last exactly one cycle. Edge selections change only while the pin is steady.

// File: rtl/trig_pwm_timer.sv
module trig_pwm_timer #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             cnt_en,
  input  logic             sw_start,
  input  logic [1:0]       edge_sel,
  input  logic             ext_start,
  input  logic             per_wr,
  input  logic [WIDTH-1:0] per_data,
  input  logic             dty_wr,
  input  logic [WIDTH-1:0] dty_data,
  output logic             pwm_out,
  output logic             tgl_out,
  output logic             per_hit,
  output logic             dty_hit
);
  localparam logic [WIDTH-1:0] PARK = '1;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  logic [WIDTH-1:0] cnt, per_reg, dty_reg, per_buf, dty_buf;
  logic             running;
  logic [2:0]       pin_q;

  wire             pin_rise = pin_q[1] & ~pin_q[2];
  wire             pin_fall = ~pin_q[1] & pin_q[2];
  wire             ext_hit  = (edge_sel[0] & pin_rise) | (edge_sel[1] & pin_fall);
  wire             start    = run_en & (sw_start | ext_hit);
  wire [WIDTH-1:0] cnt_inc  = cnt + ONE;
  wire             at_end   = cnt == per_buf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q   <= '0;
      per_reg <= '0;
      dty_reg <= '0;
    end else begin
      pin_q <= {pin_q[1:0], ext_start};
      if (per_wr) per_reg <= per_data;
      if (dty_wr) dty_reg <= dty_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= PARK;
      running <= 1'b0;
      per_buf <= '0;
      dty_buf <= '0;
      pwm_out <= 1'b0;
      tgl_out <= 1'b0;
      per_hit <= 1'b0;
      dty_hit <= 1'b0;
    end else begin
      per_hit <= 1'b0;
      dty_hit <= 1'b0;
      if (!run_en) begin
        cnt     <= PARK;
        running <= 1'b0;
        per_buf <= per_reg;
        dty_buf <= dty_reg;
        pwm_out <= 1'b0;
        tgl_out <= 1'b0;
      end else if (start) begin
        cnt     <= '0;
        running <= 1'b1;
        pwm_out <= 1'b1;
        tgl_out <= ~tgl_out;
      end else if (running && cnt_en) begin
        if (at_end) begin
          cnt     <= '0;
          per_hit <= 1'b1;
          per_buf <= per_reg;
          dty_buf <= dty_reg;
          pwm_out <= dty_reg != '0;
          dty_hit <= dty_reg == '0;
        end else begin
          cnt <= cnt_inc;
          if (cnt_inc == dty_buf) begin
            pwm_out <= 1'b0;
            dty_hit <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/trig_pwm_timer_sva.sv
module trig_pwm_timer_sva #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             start,
  input logic             running,
  input logic [WIDTH-1:0] cnt,
  input logic [WIDTH-1:0] per_buf,
  input logic [WIDTH-1:0] dty_buf,
  input logic             pwm_out,
  input logic             tgl_out,
  input logic             per_hit,
  input logic             dty_hit
);
  a_r1_idle_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> (cnt == '1 && !per_hit && !dty_hit));

  a_r3_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0 && pwm_out && running && !per_hit && !dty_hit));

  a_r3_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (tgl_out != $past(tgl_out)));

  a_r5_clear_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    per_hit |-> (cnt == '0 && running));

  a_r6_low_on_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (dty_hit && !per_hit) |-> !pwm_out);

  a_r7_buffers_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_en) && run_en && !per_hit) |-> ($stable(per_buf) && $stable(dty_buf)));

  a_r10_disable_parks: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (cnt == '1 && !pwm_out && !tgl_out && !running));
endmodule

bind trig_pwm_timer trig_pwm_timer_sva #(.WIDTH(WIDTH)) u_sva (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .start(start), .running(running),
  .cnt(cnt), .per_buf(per_buf), .dty_buf(dty_buf), .pwm_out(pwm_out),
  .tgl_out(tgl_out), .per_hit(per_hit), .dty_hit(dty_hit)
);

// File: tb/tb_trig_pwm_timer.sv
module tb_trig_pwm_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0, run_en = 1'b0, cnt_en = 1'b1, sw_start = 1'b0, ext_start = 1'b0;
  logic [1:0] edge_sel = 2'b00;
  logic per_wr = 1'b0, dty_wr = 1'b0;
  logic [W-1:0] per_data = '0, dty_data = '0;
  logic pwm_out, tgl_out, per_hit, dty_hit;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_pwm_timer #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt_en(cnt_en), .sw_start(sw_start),
    .edge_sel(edge_sel), .ext_start(ext_start), .per_wr(per_wr), .per_data(per_data),
    .dty_wr(dty_wr), .dty_data(dty_data), .pwm_out(pwm_out), .tgl_out(tgl_out),
    .per_hit(per_hit), .dty_hit(dty_hit)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic quiet(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      check({tag, " pwm"}, pwm_out, 0);
      check({tag, " tgl"}, tgl_out, 0);
      check({tag, " per_hit"}, per_hit, 0);
      check({tag, " dty_hit"}, dty_hit, 0);
      tick(1);
    end
  endtask

  task automatic follow(input int per, input int dty, input int ph0, input int n,
                        input bit skip, input bit etgl, input string tag);
    for (int i = 0; i < n; i++) begin
      int ph = (ph0 + i) % (per + 1);
      bit first = skip && (i == 0);
      check({tag, " pwm"}, pwm_out, first ? 1 : int'(ph < dty));
      check({tag, " per_hit"}, per_hit, first ? 0 : int'(ph == 0));
      check({tag, " dty_hit"}, dty_hit, first ? 0 : int'(ph == dty));
      check({tag, " tgl"}, tgl_out, etgl);
      tick(1);
    end
  endtask

  task automatic sw_fire();
    sw_start = 1'b1;
    tick(1);
    sw_start = 1'b0;
  endtask

  task automatic write_regs(input bit wp, input int p, input bit wd, input int d);
    per_wr = wp; per_data = W'(p);
    dty_wr = wd; dty_data = W'(d);
  endtask

  task automatic end_write();
    per_wr = 1'b0; dty_wr = 1'b0;
  endtask

  task automatic t_reset_idle();
    tick(3);
    rst_n = 1'b1;
    tick(1);
    quiet("R1 reset", 2);
    write_regs(1, 9, 1, 3); tick(1); end_write();
    tick(2);
    run_en = 1'b1;
    tick(1);
    quiet("R1 enabled, waiting", 20);
  endtask

  task automatic t_soft_start();
    sw_fire();
    follow(9, 3, 0, 30, 1, 1, "R2 R3 R5 R6 soft start");
  endtask

  task automatic t_reload();
    write_regs(1, 4, 1, 2);
    follow(9, 3, 0, 1, 0, 1, "R7 old values");
    end_write();
    follow(9, 3, 1, 9, 0, 1, "R7 old period kept");
    follow(4, 2, 0, 10, 0, 1, "R7 new values");
  endtask

  task automatic t_retrigger();
    follow(4, 2, 0, 2, 0, 1, "R4 before");
    sw_fire();
    follow(4, 2, 0, 6, 1, 0, "R4 restarted");
  endtask

  task automatic t_hold();
    cnt_en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      check("R9 hold pwm", pwm_out, 1);
      check("R9 hold per_hit", per_hit, 0);
      check("R9 hold dty_hit", dty_hit, 0);
      tick(1);
    end
    cnt_en = 1'b1;
    follow(4, 2, 1, 9, 0, 0, "R9 resume");
  endtask

  task automatic t_disable();
    run_en = 1'b0;
    tick(1);
    quiet("R10 disabled", 2);
    sw_fire();
    quiet("R10 start ignored", 3);
  endtask

  task automatic t_ext_rise();
    edge_sel = 2'b01;
    run_en = 1'b1;
    tick(2);
    ext_start = 1'b1;
    quiet("R8 sync latency", 3);
    follow(4, 2, 0, 5, 1, 1, "R8 rising start");
    ext_start = 1'b0;
    follow(4, 2, 0, 10, 0, 1, "R8 fall ignored on 01");
  endtask

  task automatic t_ext_fall();
    edge_sel = 2'b10;
    ext_start = 1'b1;
    follow(4, 2, 0, 5, 0, 1, "R8 rise ignored on 10");
    ext_start = 1'b0;
    follow(4, 2, 0, 3, 0, 1, "R8 fall latency");
    follow(4, 2, 0, 5, 1, 0, "R8 falling start");
  endtask

  task automatic t_ext_both();
    edge_sel = 2'b11;
    ext_start = 1'b1;
    follow(4, 2, 0, 3, 0, 0, "R8 both latency rise");
    follow(4, 2, 0, 5, 1, 1, "R8 both rising");
    ext_start = 1'b0;
    follow(4, 2, 0, 3, 0, 1, "R8 both latency fall");
    follow(4, 2, 0, 5, 1, 0, "R8 both falling");
    edge_sel = 2'b00;
  endtask

  task automatic t_duty_edges();
    write_regs(1, 3, 1, 0); tick(1); end_write();
    run_en = 1'b0;
    tick(2);
    run_en = 1'b1;
    sw_fire();
    tick(4);
    follow(3, 0, 0, 4, 0, 1, "R6 duty zero");
    write_regs(0, 0, 1, 7);
    follow(3, 0, 0, 1, 0, 1, "R6 duty zero");
    end_write();
    follow(3, 0, 1, 3, 0, 1, "R7 duty zero kept");
    follow(3, 7, 0, 8, 0, 1, "R6 duty above period");
  endtask

  initial begin
    t_reset_idle();
    t_soft_start();
    t_reload();
    t_retrigger();
    t_hold();
    t_disable();
    t_ext_rise();
    t_ext_fall();
    t_ext_both();
    t_duty_edges();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule